// File: doc/BRIEF.md
# Fetch and Memory-Access Sequencer

This block is the control state machine of a single-issue core that runs one instruction at a time. For each instruction it sends a request on an instruction port. If the instruction turns out to be a load or a store, it then sends a second request on a data port. Both ports work the same way. A request is offered for one cycle and the port either accepts it or refuses it in that cycle. A response arrives later and may be a negative acknowledgement. A refused request stays held until the port raises its retry line. A negatively acknowledged request is offered again straight away.

Decode and execution are outside the block. They appear as a one-cycle execute strobe. During that strobe the datapath reports whether the instruction references memory and whether a conditional store has already failed. The sequencer also owns the program counter. It advances the counter by a fixed step when an instruction completes, and loads a fault-handler vector when fetch setup reports a fault.

Around that loop sit several controls:
- an activate command, which starts fetching after a programmable delay;
- a suspend command;
- a switch-out and take-over pair;
- a level-sensitive drain request, which stops the core at an instruction boundary.

A busy-cycle counter and a sticky protocol-error flag make the sequencing visible to the surrounding logic.

Top module: `fetch_mem_sequencer`

## Requirements
- R1: After reset the state output reads 0, the program counter equals RESET_PC, neither port request is raised, the busy count is 0 and the error flag is low. The state codes are: 0 idle, 1 running, 2 fetch-retry, 3 fetch-wait, 4 data-retry, 5 data-wait, 6 switched-out.
- R2: An activate command in idle moves the block to running with a delay D taken from act_delay. The first fetch request appears D cycles after the block enters running, and it carries the current program counter.
- R3: A request refused by its port moves the block to that port's retry state (2 or 4). The request is offered again only in a cycle where the retry line is high. The block moves to the wait state (3 or 5) in the cycle where the port accepts.
- R4: A negative acknowledgement in a wait state re-offers the request in the same cycle. If that offer is refused, the block moves to the retry state; if it is accepted, the block stays in the wait state.
- R5: A good response whose defer bit is low is processed in its arrival cycle. A good response whose defer bit is high is processed one cycle later.
- R6: Processing a fetch response raises exec_strobe for one cycle. A non-memory instruction, or a memory instruction whose conditional store has failed early, advances the counter by STEP and returns the block to running with no data request. Any other memory instruction offers a data request in that same cycle.
- R7: A good data response advances the counter by STEP and returns the block to running.
- R8: A fetch-setup fault in a fetch cycle suppresses the fetch request. The counter becomes FAULT_VEC and the block stays running.
- R9: While drain_req is high no new fetch starts. drained rises at once in idle, running or switched-out. In a wait state, a fetch response is dropped without execution and the counter does not change, while a data response completes normally; in both cases drained then rises.
- R10: Suspend in running returns the block to idle with no fetch. Switch-out from idle or running enters state 6. Take-over from state 6 enters running when take_active is high and idle otherwise.
- R11: The busy count rises by one on every clock edge where the state is neither idle nor switched-out, and holds otherwise.
- R12: A response, retry, activate or suspend that arrives in a state where it is not legal sets proto_err. Once set, proto_err stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| act_req | input | 1 | Activate command |
| act_delay | input | DLY_W | Cycles to wait before the first fetch after activate |
| susp_req | input | 1 | Suspend command |
| swout_req | input | 1 | Switch-out command |
| take_req | input | 1 | Take-over command |
| take_active | input | 1 | Thread is active on take-over |
| drain_req | input | 1 | Drain request (level) |
| drained | output | 1 | Block is stopped at an instruction boundary |
| fetch_fault | input | 1 | Fault during fetch address setup |
| if_req_valid | output | 1 | Instruction request offered this cycle |
| if_req_pc | output | AW | Fetch address |
| if_req_accept | input | 1 | Instruction port takes the offered request |
| if_retry | input | 1 | Instruction port asks for the held request |
| if_resp_valid | input | 1 | Instruction response present |
| if_resp_nack | input | 1 | Instruction response is a negative acknowledgement |
| if_resp_defer | input | 1 | Instruction response is processed at the next edge |
| exec_strobe | output | 1 | Fetched instruction executes this cycle |
| inst_is_mem | input | 1 | Executing instruction references memory |
| inst_sc_fail | input | 1 | Conditional store failed before any access |
| dm_req_valid | output | 1 | Data request offered this cycle |
| dm_req_accept | input | 1 | Data port takes the offered request |
| dm_retry | input | 1 | Data port asks for the held request |
| dm_resp_valid | input | 1 | Data response present |
| dm_resp_nack | input | 1 | Data response is a negative acknowledgement |
| dm_resp_defer | input | 1 | Data response is processed at the next edge |
| state | output | 3 | Current state code (see R1) |
| busy_cycles | output | BUSY_W | Non-idle cycle count |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest situation to reach from the ports is a chain of events on a single instruction. A negative acknowledgement is refused on its reissue and later retried. The response after that is deferred, and the instruction it returns is a memory reference whose data request goes through the same chain. A directed sequence walks one instruction through each of these links in turn. A long run driven by $urandom then answers every offer, retry and response at random latency, with random acceptance, negative acknowledgements and deferral. In that run the bench predicts the program counter on every fetch and the execute strobe on every cycle.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_IRETRY = 3'd2,
        ST_IWAIT  = 3'd3,
        ST_DRETRY = 3'd4,
        ST_DWAIT  = 3'd5,
        ST_SWOUT  = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic nack;
        logic defer;
    } rsp_t;

    function automatic logic is_quiet(seq_state_e s);
        return (s == ST_IDLE) || (s == ST_SWOUT);
    endfunction

    function automatic logic at_boundary(seq_state_e s);
        return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_SWOUT);
    endfunction

endpackage

// File: rtl/seqc_rsp_stage.sv
module seqc_rsp_stage
    import seqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic waiting,
    input  rsp_t rsp,
    output logic done,
    output logic nack_now,
    output logic stray
);
    logic held_q;
    logic capture;

    assign capture  = waiting && rsp.valid && !rsp.nack && rsp.defer && !held_q;
    assign done     = waiting && (held_q || (rsp.valid && !rsp.nack && !rsp.defer));
    assign nack_now = waiting && !held_q && rsp.valid && rsp.nack;
    assign stray    = rsp.valid && !waiting;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= capture;
    end

    // R5: a deferred good response is processed on the following cycle
    a_r5_deferred_done: assert property (@(posedge clk) disable iff (rst)
        capture |=> done);
endmodule

// File: rtl/seqc_delay_tmr.sv
module seqc_delay_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/seqc_busy_ctr.sv
module seqc_busy_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)     count <= '0;
        else if (en) count <= count + 1'b1;
    end
endmodule

// File: rtl/fetch_mem_sequencer.sv
module fetch_mem_sequencer
    import seqc_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DLY_W     = 8,
    parameter int          BUSY_W    = 16,
    parameter logic [15:0] RESET_PC  = 16'h0100,
    parameter logic [15:0] FAULT_VEC = 16'h0F00,
    parameter int          STEP      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_req,
    input  logic [DLY_W-1:0]  act_delay,
    input  logic              susp_req,
    input  logic              swout_req,
    input  logic              take_req,
    input  logic              take_active,
    input  logic              drain_req,
    output logic              drained,
    input  logic              fetch_fault,
    output logic              if_req_valid,
    output logic [AW-1:0]     if_req_pc,
    input  logic              if_req_accept,
    input  logic              if_retry,
    input  logic              if_resp_valid,
    input  logic              if_resp_nack,
    input  logic              if_resp_defer,
    output logic              exec_strobe,
    input  logic              inst_is_mem,
    input  logic              inst_sc_fail,
    output logic              dm_req_valid,
    input  logic              dm_req_accept,
    input  logic              dm_retry,
    input  logic              dm_resp_valid,
    input  logic              dm_resp_nack,
    input  logic              dm_resp_defer,
    output logic [2:0]        state,
    output logic [BUSY_W-1:0] busy_cycles,
    output logic              proto_err
);
    localparam logic [AW-1:0] PC_INIT  = AW'(RESET_PC);
    localparam logic [AW-1:0] PC_FAULT = AW'(FAULT_VEC);
    localparam logic [AW-1:0] PC_STEP  = AW'(STEP);

    seq_state_e     st_q, st_d;
    logic [AW-1:0]  pc_q, pc_d;
    logic           err_q;
    logic           dly_zero, dly_load;
    logic [DLY_W-1:0] dly_val;
    logic           i_done, i_nack, i_stray;
    logic           d_done, d_nack, d_stray;
    logic           fetch_go, mem_go, bad_cmd;
    rsp_t           if_rsp, dm_rsp;

    assign if_rsp = '{valid: if_resp_valid, nack: if_resp_nack, defer: if_resp_defer};
    assign dm_rsp = '{valid: dm_resp_valid, nack: dm_resp_nack, defer: dm_resp_defer};

    seqc_rsp_stage u_if_rsp (
        .clk(clk), .rst(rst), .waiting(st_q == ST_IWAIT), .rsp(if_rsp),
        .done(i_done), .nack_now(i_nack), .stray(i_stray)
    );

    seqc_rsp_stage u_dm_rsp (
        .clk(clk), .rst(rst), .waiting(st_q == ST_DWAIT), .rsp(dm_rsp),
        .done(d_done), .nack_now(d_nack), .stray(d_stray)
    );

    seqc_delay_tmr #(.W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .load(dly_load), .load_val(dly_val),
        .tick(st_q == ST_RUN), .zero(dly_zero)
    );

    seqc_busy_ctr #(.W(BUSY_W)) u_busy (
        .clk(clk), .rst(rst), .en(!is_quiet(st_q)), .count(busy_cycles)
    );

    // A fetch starts only in running, with the delay expired and no command pending
    assign fetch_go = (st_q == ST_RUN) && dly_zero && !drain_req && !swout_req && !susp_req;
    assign exec_strobe = i_done && !drain_req;
    assign mem_go = exec_strobe && inst_is_mem && !inst_sc_fail;

    assign if_req_valid = (fetch_go && !fetch_fault)
                        || ((st_q == ST_IRETRY) && if_retry)
                        || i_nack;
    assign dm_req_valid = mem_go
                        || ((st_q == ST_DRETRY) && dm_retry)
                        || d_nack;
    assign if_req_pc = pc_q;
    assign drained   = drain_req && at_boundary(st_q);
    assign state     = st_q;
    assign proto_err = err_q;

    assign bad_cmd = i_stray || d_stray
                   || (if_retry && st_q != ST_IRETRY)
                   || (dm_retry && st_q != ST_DRETRY)
                   || (act_req  && st_q != ST_IDLE)
                   || (susp_req && st_q != ST_RUN);

    always_comb begin
        st_d     = st_q;
        pc_d     = pc_q;
        dly_load = 1'b0;
        dly_val  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (swout_req) st_d = ST_SWOUT;
                else if (act_req) begin
                    st_d     = ST_RUN;
                    dly_load = 1'b1;
                    dly_val  = act_delay;
                end
            end
            ST_RUN: begin
                if (swout_req)     st_d = ST_SWOUT;
                else if (susp_req) st_d = ST_IDLE;
                else if (fetch_go) begin
                    if (fetch_fault)        pc_d = PC_FAULT;
                    else if (if_req_accept) st_d = ST_IWAIT;
                    else                    st_d = ST_IRETRY;
                end
            end
            ST_IRETRY: begin
                if (if_retry && if_req_accept) st_d = ST_IWAIT;
            end
            ST_IWAIT: begin
                if (i_nack) begin
                    st_d = if_req_accept ? ST_IWAIT : ST_IRETRY;
                end else if (i_done) begin
                    if (drain_req) st_d = ST_RUN;
                    else if (mem_go) st_d = dm_req_accept ? ST_DWAIT : ST_DRETRY;
                    else begin
                        st_d = ST_RUN;
                        pc_d = pc_q + PC_STEP;
                    end
                end
            end
            ST_DRETRY: begin
                if (dm_retry && dm_req_accept) st_d = ST_DWAIT;
            end
            ST_DWAIT: begin
                if (d_nack) begin
                    st_d = dm_req_accept ? ST_DWAIT : ST_DRETRY;
                end else if (d_done) begin
                    st_d = ST_RUN;
                    pc_d = pc_q + PC_STEP;
                end
            end
            ST_SWOUT: begin
                if (take_req) begin
                    st_d     = take_active ? ST_RUN : ST_IDLE;
                    dly_load = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            pc_q  <= PC_INIT;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            pc_q  <= pc_d;
            err_q <= err_q || bad_cmd;
        end
    end

    // R3: an accepted first fetch leads to the fetch-wait state
    a_r3_fetch_accept: assert property (@(posedge clk) disable iff (rst)
        (fetch_go && if_req_valid && if_req_accept) |=> (st_q == ST_IWAIT));
    // R3: a held fetch stays in retry until the port asks for it
    a_r3_retry_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IRETRY && !if_retry) |=> (st_q == ST_IRETRY));
    // R6: execution happens only on a fetch response
    a_r6_exec_in_wait: assert property (@(posedge clk) disable iff (rst)
        exec_strobe |-> (st_q == ST_IWAIT));
    // R7/R8: the counter only steps forward or jumps to the handler
    a_r7_pc_moves: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_q) |-> (pc_q == $past(pc_q) + PC_STEP || pc_q == PC_FAULT));
    // R9: no fetch is offered while drained
    a_r9_drain_quiet: assert property (@(posedge clk) disable iff (rst)
        drained |-> !if_req_valid);
    // R11: the busy count holds in quiet states
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
        is_quiet(st_q) |=> $stable(busy_cycles));
    // R12: the error flag is sticky
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
endmodule

// File: tb/fetch_mem_sequencer_tb_top.sv
module fetch_mem_sequencer_tb_top;
    localparam int          AW   = 16;
    localparam logic [15:0] RPC  = 16'h0100;
    localparam logic [15:0] FVEC = 16'h0F00;
    localparam int          STEP = 4;

    logic clk = 1'b0;
    logic rst;
    logic act_req, susp_req, swout_req, take_req, take_active, drain_req, drained;
    logic [7:0] act_delay;
    logic fetch_fault, if_req_valid, if_req_accept, if_retry;
    logic if_resp_valid, if_resp_nack, if_resp_defer, exec_strobe;
    logic inst_is_mem, inst_sc_fail, dm_req_valid, dm_req_accept, dm_retry;
    logic dm_resp_valid, dm_resp_nack, dm_resp_defer, proto_err;
    logic [AW-1:0] if_req_pc;
    logic [2:0] state;
    logic [15:0] busy_cycles;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    fetch_mem_sequencer dut_i (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done_flag) begin
            done_flag = 1;
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp=<finish>", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic clr();
        act_req = 0; act_delay = 0; susp_req = 0; swout_req = 0; take_req = 0;
        take_active = 0; drain_req = 0; fetch_fault = 0; if_req_accept = 0;
        if_retry = 0; if_resp_valid = 0; if_resp_nack = 0; if_resp_defer = 0;
        inst_is_mem = 0; inst_sc_fail = 0; dm_req_accept = 0; dm_retry = 0;
        dm_resp_valid = 0; dm_resp_nack = 0; dm_resp_defer = 0;
    endtask

    task automatic step();
        @(negedge clk);
        clr();
    endtask

    task automatic do_reset();
        @(negedge clk);
        clr();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return p + AW'(STEP);
    endfunction

    int b0;
    logic [AW-1:0] exp_pc;
    bit held_i, held_d;
    int lat_i, lat_d;
    bit ev_i, ev_d;

    initial begin
        clr();
        do_reset();
        step(); #1;
        // R1 reset state
        chk(state == 0, "R1 state", state, 0);
        chk(if_req_pc == RPC, "R1 pc", if_req_pc, RPC);
        chk(!if_req_valid && !dm_req_valid, "R1 no req", if_req_valid, 0);
        chk(busy_cycles == 0 && !proto_err, "R1 busy/err", busy_cycles, 0);
        step(); step(); #1;
        chk(busy_cycles == 0, "R11 idle hold", busy_cycles, 0);

        // R2 activate with delay 3
        step(); act_req = 1; act_delay = 3;
        for (int i = 0; i < 3; i++) begin
            step(); #1;
            chk(state == 1 && !if_req_valid, "R2 delay", if_req_valid, 0);
        end
        step(); #1;
        chk(if_req_valid && if_req_pc == RPC, "R2 first fetch", if_req_pc, RPC);
        step(); #1;
        chk(state == 2 && !if_req_valid, "R3 refused to retry", state, 2);
        step(); if_retry = 1; #1;
        chk(if_req_valid, "R3 resend on retry", if_req_valid, 1);
        step(); if_retry = 1; if_req_accept = 1; #1;
        chk(state == 2, "R3 still retry", state, 2);
        step(); #1;
        chk(state == 3, "R3 accept to wait", state, 3);
        if_resp_valid = 1; if_resp_defer = 1; #1;
        chk(!exec_strobe, "R5 deferred not now", exec_strobe, 0);
        step(); #1;
        chk(state == 3 && exec_strobe, "R5 deferred next", exec_strobe, 1);
        step(); if_req_accept = 1; #1;
        chk(state == 1 && if_req_pc == nxt(RPC), "R6 nonmem advance", if_req_pc, nxt(RPC));
        step(); if_resp_valid = 1; if_resp_nack = 1; #1;
        chk(if_req_valid, "R4 nack resend", if_req_valid, 1);
        step(); #1;
        chk(state == 2, "R4 refused resend", state, 2);
        if_retry = 1; if_req_accept = 1;
        step(); if_resp_valid = 1; inst_is_mem = 1; #1;
        chk(exec_strobe && dm_req_valid, "R6 mem issues data", dm_req_valid, 1);
        step(); #1;
        chk(state == 4, "R3 data retry", state, 4);
        dm_retry = 1; dm_req_accept = 1;
        step(); #1;
        chk(state == 5, "R3 data wait", state, 5);
        dm_resp_valid = 1;
        step(); fetch_fault = 1; #1;
        chk(state == 1 && if_req_pc == nxt(nxt(RPC)), "R7 data done", if_req_pc, nxt(nxt(RPC)));
        chk(!if_req_valid, "R8 fault no req", if_req_valid, 0);
        step(); if_req_accept = 1; #1;
        chk(state == 1 && if_req_pc == FVEC, "R8 fault vector", if_req_pc, FVEC);
        step(); if_resp_valid = 1; inst_is_mem = 1; inst_sc_fail = 1; #1;
        chk(exec_strobe && !dm_req_valid, "R6 sc fail no data", dm_req_valid, 0);
        step(); drain_req = 1; #1;
        chk(if_req_pc == nxt(FVEC), "R6 sc fail advance", if_req_pc, nxt(FVEC));
        chk(drained && !if_req_valid, "R9 drain in run", drained, 1);
        b0 = busy_cycles;
        for (int i = 0; i < 4; i++) begin step(); drain_req = 1; end
        #1;
        chk(busy_cycles == b0 + 4, "R11 busy count", busy_cycles, b0 + 4);
        drain_req = 0; if_req_accept = 1;
        step(); drain_req = 1; if_resp_valid = 1; #1;
        chk(!drained && !exec_strobe, "R9 drain pending", drained, 0);
        step(); drain_req = 1; #1;
        chk(state == 1 && drained && if_req_pc == nxt(FVEC), "R9 drop fetch", if_req_pc, nxt(FVEC));
        step(); susp_req = 1; #1;
        chk(!if_req_valid, "R10 suspend no fetch", if_req_valid, 0);
        step(); swout_req = 1; #1;
        chk(state == 0, "R10 suspend idle", state, 0);
        step(); #1;
        chk(state == 6, "R10 switched out", state, 6);
        b0 = busy_cycles;
        step(); step(); take_req = 1; take_active = 1; #1;
        chk(busy_cycles == b0, "R11 swout hold", busy_cycles, b0);
        step(); swout_req = 1; #1;
        chk(state == 1, "R10 take active", state, 1);
        step(); take_req = 1; #1;
        chk(state == 6, "R10 swout from run", state, 6);
        step(); #1;
        chk(state == 0 && !proto_err, "R10 take inactive", state, 0);
        if_resp_valid = 1;
        step(); step(); #1;
        chk(proto_err, "R12 sticky err", proto_err, 1);

        // Random run: R3 R4 R5 R6 R7 R8
        do_reset();
        step(); act_req = 1;
        exp_pc = RPC; held_i = 0; held_d = 0; lat_i = 1; lat_d = 1;
        for (int n = 0; n < 4000; n++) begin
            step();
            inst_is_mem = ($urandom % 2) == 1;
            inst_sc_fail = ($urandom % 5) == 0;
            ev_i = 0; ev_d = 0;
            case (state)
                3'd1: begin
                    if_req_accept = ($urandom % 2) == 1;
                    fetch_fault = ($urandom % 10) == 0;
                end
                3'd2: begin
                    if_retry = ($urandom % 2) == 1;
                    if_req_accept = ($urandom % 2) == 1;
                end
                3'd3: begin
                    dm_req_accept = ($urandom % 2) == 1;
                    if (held_i) begin ev_i = 1; held_i = 0; end
                    else if (lat_i == 0) begin
                        if_resp_valid = 1;
                        if_resp_nack = ($urandom % 4) == 0;
                        if_resp_defer = ($urandom % 3) == 0;
                        if_req_accept = ($urandom % 2) == 1;
                        if (!if_resp_nack && if_resp_defer) held_i = 1;
                        else if (!if_resp_nack) ev_i = 1;
                        lat_i = $urandom % 3;
                    end else lat_i--;
                end
                3'd4: begin
                    dm_retry = ($urandom % 2) == 1;
                    dm_req_accept = ($urandom % 2) == 1;
                end
                3'd5: begin
                    if (held_d) begin ev_d = 1; held_d = 0; end
                    else if (lat_d == 0) begin
                        dm_resp_valid = 1;
                        dm_resp_nack = ($urandom % 4) == 0;
                        dm_resp_defer = ($urandom % 3) == 0;
                        dm_req_accept = ($urandom % 2) == 1;
                        if (!dm_resp_nack && dm_resp_defer) held_d = 1;
                        else if (!dm_resp_nack) ev_d = 1;
                        lat_d = $urandom % 3;
                    end else lat_d--;
                end
                default: ;
            endcase
            #1;
            if (state == 1) begin
                if (fetch_fault) begin
                    chk(!if_req_valid, "R8 random fault", if_req_valid, 0);
                    exp_pc = FVEC;
                end else
                    chk(if_req_valid && if_req_pc == exp_pc, "R6 random fetch pc", if_req_pc, exp_pc);
            end
            if (state == 3) begin
                chk(exec_strobe == ev_i, "R5 random exec", exec_strobe, ev_i);
                if (if_resp_valid && if_resp_nack)
                    chk(if_req_valid, "R4 random nack", if_req_valid, 1);
                if (ev_i && inst_is_mem && !inst_sc_fail)
                    chk(dm_req_valid, "R6 random data req", dm_req_valid, 1);
                else if (ev_i) exp_pc = nxt(exp_pc);
            end
            if (state == 5) begin
                if (dm_resp_valid && dm_resp_nack)
                    chk(dm_req_valid, "R4 random data nack", dm_req_valid, 1);
                if (ev_d) exp_pc = nxt(exp_pc);
            end
            if (state == 2 && !if_retry)
                chk(!if_req_valid, "R3 random held", if_req_valid, 0);
        end
        step(); #1;
        chk(!proto_err, "R12 no err on legal traffic", proto_err, 0);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule